// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to eight interrupt request lines into a single interrupt line towards a CPU. Each line can be set to trigger on a rising edge or on a held level, and each can be masked. When the CPU acknowledges an interrupt, the controller marks the winning line as in service and returns a vector byte. The vector is a programmable base followed by the number of the winning line.

While a line is in service, it blocks arbitration for itself and for every line of lower priority. Lines of higher priority still get through, so handlers can nest. Software releases a level by writing an end-of-interrupt command that names that level. A small registered bus lets software write the mask, mode, vector base and end-of-interrupt commands. The same bus reads back the pending requests and the in-service set.

Line 0 has the highest priority and line 7 the lowest. The priority order is fixed.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_irq` is 0, `vec_out` is 0, and the in-service set, mask, mode and vector base all read 0 (every line level mode, unmasked).
- R2: In edge mode (mode bit i = 1), line i requests only after a 0-to-1 transition. The latched request clears when line i is acknowledged, so a line that stays high afterwards raises no further request.
- R3: In level mode (mode bit i = 0), line i requests in every cycle it is high and stores nothing.
- R4: A line whose mask bit is 1 takes no part in arbitration, yet its edges are still latched and show as pending. Clearing the mask bit lets the held request through.
- R5: `cpu_irq` is registered. It is 1 in the cycle after some unmasked, unblocked request exists and 0 in the cycle after none exists. When several requests compete, the lowest line number wins.
- R6: A one-cycle `inta` pulse moves the winning line into the in-service set. From the next cycle, `vec_out` holds {base[4:0], line[2:0]}.
- R7: An in-service line blocks requests from itself and from every higher-numbered line. Lower-numbered lines still raise `cpu_irq` and can be acknowledged (nesting).
- R8: Writing address 3 with data[2:0] = k clears in-service bit k only. An end-of-interrupt that names a line not in service leaves the in-service set unchanged.
- R9: An `inta` with no eligible request changes no state and sets `vec_out` to {base, 3'b111}.
- R10: Bus writes take effect at the clock edge. Write addresses: 0 is the mask, 1 is the mode (1 = edge), 2 is the base in data[4:0], and 3 is the end-of-interrupt command. `bus_rdata` is registered and shows the selected register one cycle after `bus_addr`. Read addresses: 0 is the mask, 1 the mode, 2 the base, 4 the pending requests (before masking), 5 the in-service set. Addresses 3, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| inta | input | 1 | One-cycle interrupt acknowledge pulse from the CPU |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Vector byte captured on acknowledge |

## Verification
Each error in the in-service set shows up at the ports within one or two cycles.
- A bit that is wrongly left set silences `cpu_irq` for its own line and every lower-priority line.
- A bit that is wrongly cleared lets a request of equal or lower priority raise `cpu_irq` again one cycle later.
- Both errors also appear directly on a bus read of address 5.

A lost or doubled edge latch shows up in the pending read. It also shows up as a missing or extra `cpu_irq` after an acknowledge. A wrong winner shows up in the low three bits of `vec_out` in the cycle after `inta`.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MASK = 3'd0,
    RA_MODE = 3'd1,
    RA_BASE = 3'd2,
    RA_EOI  = 3'd3,
    RA_PEND = 3'd4,
    RA_INSV = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/vic_req_latch.sv
module vic_req_latch #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] mode_edge,
  input  logic [N_IN-1:0] ack_clr,
  output logic [N_IN-1:0] req
);
  // One latch per line; level-mode lines bypass it.
  for (genvar i = 0; i < N_IN; i++) begin : g_line
    logic prev_q;
    logic edge_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        edge_q <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        if (!mode_edge[i])
          edge_q <= 1'b0;
        else if (irq_in[i] && !prev_q)
          edge_q <= 1'b1;
        else if (ack_clr[i])
          edge_q <= 1'b0;
      end
    end
    assign req[i] = mode_edge[i] ? edge_q : irq_in[i];
  end
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
  parameter int N_IN  = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_IN-1:0]  req,
  input  logic [N_IN-1:0]  mask,
  input  logic [N_IN-1:0]  isr,
  output logic             cand_any,
  output logic [IDX_W-1:0] win_idx,
  output logic [N_IN-1:0]  win_oh
);
  logic [N_IN-1:0] blk;
  logic [N_IN-1:0] cand;

  // blk[i] is set when any line at or above priority i is in service
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      acc    = acc | isr[i];
      blk[i] = acc;
    end
  end

  assign cand     = req & ~mask & ~blk;
  assign cand_any = |cand;
  assign win_oh   = cand & (~cand + N_IN'(1));

  // Lowest set index wins; with no candidate the lowest-priority code results
  always_comb begin
    win_idx = IDX_W'(N_IN - 1);
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8,
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_IN-1:0]   pend,
  input  logic [N_IN-1:0]   isr,
  output logic [N_IN-1:0]   mask_q,
  output logic [N_IN-1:0]   mode_q,
  output logic [BASE_W-1:0] base_q,
  output logic [N_IN-1:0]   eoi_oh,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rdata_n;
  logic              eoi_hit;

  assign eoi_hit = bus_wr && (reg_addr_e'(bus_addr) == RA_EOI)
                   && (int'(bus_wdata[IDX_W-1:0]) < N_IN);
  assign eoi_oh  = eoi_hit ? (N_IN'(1) << bus_wdata[IDX_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      mode_q <= '0;
      base_q <= '0;
    end else if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        RA_MASK: mask_q <= bus_wdata[N_IN-1:0];
        RA_MODE: mode_q <= bus_wdata[N_IN-1:0];
        RA_BASE: base_q <= bus_wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_MASK: rdata_n = DATA_W'(mask_q);
      RA_MODE: rdata_n = DATA_W'(mode_q);
      RA_BASE: rdata_n = DATA_W'(base_q);
      RA_PEND: rdata_n = DATA_W'(pend);
      RA_INSV: rdata_n = DATA_W'(isr);
      default: rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_n;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              inta,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq,
  output logic [VEC_W-1:0]  vec_out
);
  localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int BASE_W = VEC_W - IDX_W;

  logic [N_IN-1:0]   req;
  logic [N_IN-1:0]   mask_q;
  logic [N_IN-1:0]   mode_q;
  logic [BASE_W-1:0] base_q;
  logic [N_IN-1:0]   eoi_oh;
  logic [N_IN-1:0]   isr_q;
  logic              cand_any;
  logic [IDX_W-1:0]  win_idx;
  logic [N_IN-1:0]   win_oh;
  logic [N_IN-1:0]   ack_oh;
  logic              cpu_irq_q;
  logic [VEC_W-1:0]  vec_q;

  assign ack_oh = inta ? win_oh : '0;

  vic_req_latch #(.N_IN(N_IN)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .mode_edge (mode_q),
    .ack_clr   (ack_oh),
    .req       (req)
  );

  vic_prio_arb #(.N_IN(N_IN), .IDX_W(IDX_W)) u_arb (
    .req      (req),
    .mask     (mask_q),
    .isr      (isr_q),
    .cand_any (cand_any),
    .win_idx  (win_idx),
    .win_oh   (win_oh)
  );

  vic_regs #(.N_IN(N_IN), .IDX_W(IDX_W), .DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend      (req),
    .isr       (isr_q),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .base_q    (base_q),
    .eoi_oh    (eoi_oh),
    .rdata_q   (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      cpu_irq_q <= 1'b0;
      vec_q     <= '0;
    end else begin
      isr_q     <= (isr_q | ack_oh) & ~eoi_oh;
      cpu_irq_q <= cand_any;
      if (inta) vec_q <= {base_q, win_idx};
    end
  end

  assign cpu_irq = cpu_irq_q;
  assign vec_out = vec_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N_IN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            inta,
  input logic            cpu_irq,
  input logic [N_IN-1:0] isr,
  input logic [N_IN-1:0] req,
  input logic [N_IN-1:0] mask,
  input logic [N_IN-1:0] eoi_oh
);
  logic [N_IN-1:0] low_isr;
  assign low_isr = isr & (~isr + N_IN'(1));

  // R6: in-service bits appear only on an acknowledge
  assert_set_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
    !inta |=> ((isr & ~$past(isr)) == '0));

  // R6: at most one line enters service per cycle
  assert_single_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr & ~$past(isr)));

  // R8: in-service bits leave only through an end-of-interrupt
  assert_clear_by_eoi_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_oh == '0) |=> (($past(isr) & ~isr) == '0));

  // R7: a nested entry always outranks everything already in service
  assert_nest_higher_R7: assert property (@(posedge clk) disable iff (rst)
    (inta && (isr != '0)) |=> ((isr & ~$past(isr)) < $past(low_isr)));

  // R5: the CPU line is raised only for an unmasked request
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(|(req & ~mask)));
endmodule

bind vec_irq_ctrl vic_chk #(.N_IN(N_IN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inta    (inta),
  .cpu_irq (cpu_irq),
  .isr     (isr_q),
  .req     (req),
  .mask    (mask_q),
  .eoi_oh  (eoi_oh)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       inta = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cpu_irq;
  logic [7:0] vec_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  vec_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .inta(inta),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .vec_out(vec_out)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [7:0] m_mask, m_mode, m_edge, m_prev, m_isr;
  logic [4:0] m_base;
  logic       e_irq;
  logic [7:0] e_vec, e_rd;

  function automatic logic [7:0] f_pend(input logic [7:0] mode, input logic [7:0] edg,
                                        input logic [7:0] lines);
    return (mode & edg) | (~mode & lines);
  endfunction

  function automatic logic [7:0] f_cand(input logic [7:0] pend, input logic [7:0] mask,
                                        input logic [7:0] isr);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      bit blocked = 1'b0;
      for (int j = 0; j <= i; j++) if (isr[j]) blocked = 1'b1;
      c[i] = pend[i] && !mask[i] && !blocked;
    end
    return c;
  endfunction

  function automatic logic [2:0] f_win(input logic [7:0] c);
    for (int i = 0; i < 8; i++) if (c[i]) return 3'(i);
    return 3'd7;
  endfunction

  function automatic logic [7:0] f_read(input logic [2:0] a, input logic [7:0] pend);
    case (a)
      3'd0: return m_mask;
      3'd1: return m_mode;
      3'd2: return {3'b000, m_base};
      3'd4: return pend;
      3'd5: return m_isr;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] pend, cand, gain, clr;
    logic [2:0] w;
    if (rst) begin
      m_mask = '0; m_mode = '0; m_edge = '0; m_prev = '0; m_isr = '0; m_base = '0;
      e_irq = 1'b0; e_vec = '0; e_rd = '0;
    end else begin
      pend  = f_pend(m_mode, m_edge, irq_in);
      cand  = f_cand(pend, m_mask, m_isr);
      w     = f_win(cand);
      e_irq = |cand;
      e_rd  = f_read(bus_addr, pend);
      gain  = (inta && cand != 0) ? (8'h01 << w) : 8'h00;
      if (inta) e_vec = {m_base, w};
      for (int i = 0; i < 8; i++) begin
        if (!m_mode[i]) m_edge[i] = 1'b0;
        else if (irq_in[i] && !m_prev[i]) m_edge[i] = 1'b1;
        else if (gain[i]) m_edge[i] = 1'b0;
      end
      clr   = (bus_wr && bus_addr == 3'd3) ? (8'h01 << bus_wdata[2:0]) : 8'h00;
      m_isr = (m_isr | gain) & ~clr;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_mask = bus_wdata;
          3'd1: m_mode = bus_wdata;
          3'd2: m_base = bus_wdata[4:0];
          default: ;
        endcase
      end
      m_prev = irq_in;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 cpu_irq", {7'b0, cpu_irq}, {7'b0, e_irq});
      chk("R6 vec_out", vec_out, e_vec);
      chk("R10 bus_rdata", bus_rdata, e_rd);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    tick();
    d = bus_rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    inta = 1'b1;
    tick();
    inta = 1'b0;
    v = vec_out;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cool;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1 cpu_irq", {7'b0, cpu_irq}, 8'h00);
    chk("R1 vec_out", vec_out, 8'h00);
    rd(3'd0, v); chk("R1 mask", v, 8'h00);
    rd(3'd1, v); chk("R1 mode", v, 8'h00);
    rd(3'd5, v); chk("R1 isr", v, 8'h00);

    // R3/R5/R6/R7/R8: level lines and nesting
    wr(3'd2, 8'h0C);
    irq_in[5] = 1'b1; tick(2);
    chk("R3 level raises irq", {7'b0, cpu_irq}, 8'h01);
    ack(v); chk("R6 vector line 5", v, 8'h65);
    rd(3'd5, v); chk("R6 isr after ack", v, 8'h20);
    irq_in[6] = 1'b1; tick(2);
    chk("R7 lower level blocked", {7'b0, cpu_irq}, 8'h00);
    irq_in[2] = 1'b1; tick(2);
    chk("R7 higher level nests", {7'b0, cpu_irq}, 8'h01);
    ack(v); chk("R5 winner is line 2", v, 8'h62);
    rd(3'd5, v); chk("R7 nested isr", v, 8'h24);
    wr(3'd3, 8'h03);
    rd(3'd5, v); chk("R8 wrong eoi keeps isr", v, 8'h24);
    wr(3'd3, 8'h02);
    rd(3'd5, v); chk("R8 eoi clears only named", v, 8'h20);
    irq_in[2] = 1'b0; tick(2);
    chk("R7 line 6 still blocked by 5", {7'b0, cpu_irq}, 8'h00);
    wr(3'd3, 8'h05); tick();
    chk("R3 held level requests again", {7'b0, cpu_irq}, 8'h01);
    ack(v); chk("R5 line 5 before line 6", v, 8'h65);
    irq_in[5] = 1'b0; wr(3'd3, 8'h05); tick(2);
    ack(v); chk("R6 vector line 6", v, 8'h66);
    irq_in[6] = 1'b0; wr(3'd3, 8'h06); tick(2);
    chk("R5 irq drops with no request", {7'b0, cpu_irq}, 8'h00);

    // R2: edge mode
    wr(3'd1, 8'h02);
    irq_in[1] = 1'b1; tick(2);
    chk("R2 rising edge requests", {7'b0, cpu_irq}, 8'h01);
    ack(v); chk("R2 vector line 1", v, 8'h61);
    wr(3'd3, 8'h01); tick(3);
    chk("R2 held high no new request", {7'b0, cpu_irq}, 8'h00);
    rd(3'd4, v); chk("R2 latch cleared by ack", v, 8'h00);
    irq_in[1] = 1'b0; tick();
    irq_in[1] = 1'b1; tick(2);
    chk("R2 new edge requests", {7'b0, cpu_irq}, 8'h01);
    ack(v); wr(3'd3, 8'h01);
    irq_in[1] = 1'b0;

    // R4: mask keeps the edge latched
    wr(3'd1, 8'h0A);
    wr(3'd0, 8'h08);
    irq_in[3] = 1'b1; tick();
    irq_in[3] = 1'b0; tick(2);
    chk("R4 masked edge no irq", {7'b0, cpu_irq}, 8'h00);
    rd(3'd4, v); chk("R4 masked edge pending", v, 8'h08);
    wr(3'd0, 8'h00); tick();
    chk("R4 unmask releases request", {7'b0, cpu_irq}, 8'h01);
    ack(v); chk("R4 vector line 3", v, 8'h63);
    wr(3'd3, 8'h03); tick(2);

    // R9: spurious acknowledge
    ack(v); chk("R9 spurious vector", v, 8'h67);
    rd(3'd5, v); chk("R9 isr unchanged", v, 8'h00);
    rd(3'd4, v); chk("R9 pending unchanged", v, 8'h00);

    // R10: read map
    rd(3'd6, v); chk("R10 unused address", v, 8'h00);
    rd(3'd2, v); chk("R10 base read", v, 8'h0C);
    rd(3'd1, v); chk("R10 mode read", v, 8'h0A);

    // Random phase, compared cycle by cycle against the model
    cool = 0;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 8) irq_in[$urandom % 8] ^= 1'b1;
      inta = 1'b0; bus_wr = 1'b0;
      if (cool > 0) cool--;
      if (cpu_irq && cool == 0 && ($urandom % 3 == 0)) begin
        inta = 1'b1; cool = 2;
      end else if ($urandom % 40 == 0) begin
        inta = 1'b1;
      end
      r = int'($urandom % 100);
      if (r < 12) begin
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'($urandom % 8);
      end else if (r < 14) begin
        bus_wr = 1'b1; bus_addr = 3'($urandom % 3); bus_wdata = 8'($urandom);
      end else begin
        bus_addr = 3'($urandom);
      end
      tick();
    end
    inta = 1'b0; bus_wr = 1'b0;
    tick(2);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule